// File: doc/BRIEF.md
# Chained Retriggerable Watchdog Counter Bank

This block holds a small bank of 64-bit down-counters that software reaches over a simple register bus. Each counter has a reload value and a control word. The control word selects the mode, the retrigger source and a clock prescaler. A counter in one-shot mode runs once each time software turns its enable on. A counter in hardware-signal mode reloads and restarts whenever the counter ranked just below it reaches end count.

The two modes are meant to work as a pair. One counter acts as the watchdog in hardware-signal mode, and its neighbour is a one-shot counter loaded with zero. To keep the watchdog alive, software turns that one-shot counter's enable off and on again. The one-shot counter then reaches end count at once, and the hardware trigger path reloads the watchdog, so the watchdog itself is never stopped. A select register picks which counters are watchdogs. When a selected, enabled counter expires, the block raises a reset request that stays high until the block is reset.

Top module: `wdc_bank`

## Requirements
- R1: After reset, every control word, every count word and the select register read as zero, and `rstReq` is low.
- R2: The control word of counter n sits at byte offset n*0x10. Its fields are: bit 0 enable, bit 1 active, bits [3:2] mode, bits [7:4] retrigger source, bits [15:8] prescaler. Bit 1 is read-only, and bits [31:16] read as zero.
- R3: An active counter decrements once every P clock cycles. P is the prescaler value, but any value below 2 acts as 2. A one-shot counter with reload R (R > 0) reaches end count P*R cycles after the enabling write.
- R4: Writes to offset +0x4 set the low 32 bits of the reload value, and writes to +0x8 set the high 32 bits. A read at +0x4 returns the low 32 bits of the live count.
- R5: A counter loaded with a zero reload signals end count in the same cycle as the load and does not become active.
- R6: A counter in mode 2'b11 whose source is 4'h5 is reloaded by every end count of counter n-1, where counter 0 follows counter N-1. This happens only while its enable bit is set. Any other source value never reloads it.
- R7: A counter in any mode other than 2'b11 starts only when a write turns its enable on from off. After end count it stays idle, even if enable=1 is written again while enable is already set.
- R8: The select register at byte offset 0x40 holds one bit per counter, where bit n selects counter n, and reads back through bits [3:0]. An end count of a selected, enabled counter raises `rstReq` one cycle later. An unselected counter never does.
- R9: Once `rstReq` is high, it stays high until reset.
- R10: If a retrigger arrives in the same cycle as a counter's final decrement, the reload wins. No end count occurs, and a full new period starts.
- R11: A read at +0x4 captures the high half of the live count. The next read at +0x8 returns that captured value, even after the count has borrowed across bit 32.
- R12: Read data appears on `busRdata` in the cycle after `busRd` is sampled, and it holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| rstReq | output | 1 | Sticky watchdog reset request |

## Verification
The critical coincidence is a keep-alive retrigger that lands on the very edge where the watchdog counter would step from one to zero. The bench tracks every clock edge by number. It places the disable write and the re-enable write of the one-shot neighbour so that the hardware reload falls exactly on the predicted expiry edge. The bench then checks that `rstReq` stays low one edge later, and that it rises exactly one full period plus one cycle after the collision.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int NUM_CNT  = 4;
  localparam int CNT_W    = 64;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 8;
  localparam int PRE_W    = 8;
  localparam int STRIDE_B = 4;                      // 16-byte window per counter
  localparam int IDX_W    = ADDR_W - STRIDE_B;
  localparam logic [ADDR_W-1:0] SEL_ADDR = 8'h40;
  localparam logic [STRIDE_B-1:0] OFF_CTRL = 4'h0;
  localparam logic [STRIDE_B-1:0] OFF_LO   = 4'h4;
  localparam logic [STRIDE_B-1:0] OFF_HI   = 4'h8;
  localparam logic [1:0] MODE_HWSIG = 2'b11;
  localparam logic [3:0] SRC_PREV   = 4'h5;
  localparam logic [PRE_W-1:0] PRE_FLOOR = 8'd2;

  typedef struct packed {
    logic [NUM_CNT-1:0] ctrlWr;
    logic [NUM_CNT-1:0] loWr;
    logic [NUM_CNT-1:0] hiWr;
    logic [NUM_CNT-1:0] loRd;
    logic               selWr;
    logic [BUS_W-1:0]   data;
  } strobe_t;
endpackage

// File: rtl/wdc_regif.sv
module wdc_regif
  import wdc_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busWr,
  input  logic                            busRd,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [BUS_W-1:0]                busWdata,
  input  logic [NUM_CNT-1:0][BUS_W-1:0]   ctrlWords,
  input  logic [NUM_CNT-1:0][BUS_W-1:0]   countLo,
  input  logic [NUM_CNT-1:0][BUS_W-1:0]   hiLatch,
  input  logic [NUM_CNT-1:0]              wdSel,
  output strobe_t                         strb,
  output logic [BUS_W-1:0]                busRdata
);
  logic [IDX_W-1:0]    cntIdx;
  logic [STRIDE_B-1:0] offs;
  logic [BUS_W-1:0]    rdNext;

  assign cntIdx = busAddr[ADDR_W-1:STRIDE_B];
  assign offs   = busAddr[STRIDE_B-1:0];

  always_comb begin
    strb        = '0;
    strb.data   = busWdata;
    strb.selWr  = busWr && (busAddr == SEL_ADDR);
    rdNext      = '0;
    if (busAddr == SEL_ADDR) rdNext[NUM_CNT-1:0] = wdSel;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (cntIdx == IDX_W'(i)) begin
        strb.ctrlWr[i] = busWr && (offs == OFF_CTRL);
        strb.loWr[i]   = busWr && (offs == OFF_LO);
        strb.hiWr[i]   = busWr && (offs == OFF_HI);
        strb.loRd[i]   = busRd && (offs == OFF_LO);
        case (offs)
          OFF_CTRL: rdNext = ctrlWords[i];
          OFF_LO:   rdNext = countLo[i];
          OFF_HI:   rdNext = hiLatch[i];
          default:  rdNext = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      busRdata <= '0;
    else if (busRd) busRdata <= rdNext;
  end
endmodule

// File: rtl/wdc_slice.sv
module wdc_slice
  import wdc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic             loWr,
  input  logic             hiWr,
  input  logic             loRd,
  input  logic [BUS_W-1:0] wdata,
  input  logic             prevEnd,
  output logic             endEvt,
  output logic             active,
  output logic             enable,
  output logic [BUS_W-1:0] ctrlWord,
  output logic [BUS_W-1:0] countLo,
  output logic [BUS_W-1:0] hiLatch
);
  logic [1:0]       mode;
  logic [3:0]       src;
  logic [PRE_W-1:0] pre, preEff, divCnt;
  logic [CNT_W-1:0] reload, count;
  logic             disWr, startOs, trig, load, tick;

  assign disWr   = ctrlWr && !wdata[0];
  assign startOs = ctrlWr && wdata[0] && !enable && (wdata[3:2] != MODE_HWSIG);
  assign trig    = (mode == MODE_HWSIG) && enable && !disWr && (src == SRC_PREV) && prevEnd;
  assign load    = startOs || trig;
  assign preEff  = (pre < PRE_FLOOR) ? PRE_FLOOR : pre;
  assign tick    = (divCnt == preEff - PRE_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable  <= 1'b0;
      mode    <= '0;
      src     <= '0;
      pre     <= '0;
      reload  <= '0;
      count   <= '0;
      divCnt  <= '0;
      active  <= 1'b0;
      endEvt  <= 1'b0;
      hiLatch <= '0;
    end else begin
      endEvt <= 1'b0;
      if (ctrlWr) begin
        enable <= wdata[0];
        mode   <= wdata[3:2];
        src    <= wdata[7:4];
        pre    <= wdata[15:8];
      end
      if (loWr) reload[BUS_W-1:0]     <= wdata;
      if (hiWr) reload[CNT_W-1:BUS_W] <= wdata;
      if (loRd) hiLatch <= count[CNT_W-1:BUS_W];
      if (load) begin
        count  <= reload;
        divCnt <= '0;
        if (reload == '0) begin
          active <= 1'b0;
          endEvt <= 1'b1;
        end else begin
          active <= 1'b1;
        end
      end else if (disWr) begin
        active <= 1'b0;
        divCnt <= '0;
      end else if (active) begin
        if (tick) begin
          divCnt <= '0;
          count  <= count - CNT_W'(1);
          if (count == CNT_W'(1)) begin
            active <= 1'b0;
            endEvt <= 1'b1;
          end
        end else begin
          divCnt <= divCnt + PRE_W'(1);
        end
      end
    end
  end

  assign ctrlWord = {{(BUS_W-16){1'b0}}, pre, src, mode, active, enable};
  assign countLo  = count[BUS_W-1:0];
endmodule

// File: rtl/wdc_datapath.sv
module wdc_datapath
  import wdc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  output logic [NUM_CNT-1:0][BUS_W-1:0] ctrlWords,
  output logic [NUM_CNT-1:0][BUS_W-1:0] countLo,
  output logic [NUM_CNT-1:0][BUS_W-1:0] hiLatch,
  output logic [NUM_CNT-1:0]            wdSel,
  output logic [NUM_CNT-1:0]            activeVec,
  output logic [NUM_CNT-1:0]            endVec,
  output logic                          rstReq
);
  logic [NUM_CNT-1:0] enVec;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam int PREV = (i == 0) ? NUM_CNT - 1 : i - 1;
    wdc_slice u_slice (
      .clk      (clk),
      .rstN     (rstN),
      .ctrlWr   (strb.ctrlWr[i]),
      .loWr     (strb.loWr[i]),
      .hiWr     (strb.hiWr[i]),
      .loRd     (strb.loRd[i]),
      .wdata    (strb.data),
      .prevEnd  (endVec[PREV]),
      .endEvt   (endVec[i]),
      .active   (activeVec[i]),
      .enable   (enVec[i]),
      .ctrlWord (ctrlWords[i]),
      .countLo  (countLo[i]),
      .hiLatch  (hiLatch[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdSel  <= '0;
      rstReq <= 1'b0;
    end else begin
      if (strb.selWr) wdSel <= strb.data[NUM_CNT-1:0];
      if (|(endVec & wdSel & enVec)) rstReq <= 1'b1;
    end
  end
endmodule

// File: rtl/wdc_bank.sv
module wdc_bank
  import wdc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              rstReq
);
  strobe_t                       strb;
  logic [NUM_CNT-1:0][BUS_W-1:0] ctrlWords, countLo, hiLatch;
  logic [NUM_CNT-1:0]            wdSel, activeVec, endVec;

  wdc_regif u_regif (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .ctrlWords(ctrlWords), .countLo(countLo),
    .hiLatch(hiLatch), .wdSel(wdSel), .strb(strb), .busRdata(busRdata)
  );

  wdc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ctrlWords(ctrlWords),
    .countLo(countLo), .hiLatch(hiLatch), .wdSel(wdSel),
    .activeVec(activeVec), .endVec(endVec), .rstReq(rstReq)
  );
endmodule

// File: rtl/wdc_checker.sv
module wdc_checker
  import wdc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               busRd,
  input logic [BUS_W-1:0]   busRdata,
  input logic               rstReq,
  input logic [NUM_CNT-1:0] wdSel,
  input logic [NUM_CNT-1:0] activeVec,
  input logic [NUM_CNT-1:0] endVec
);
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> rstReq); // R9

  AST_RST_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> ($past(wdSel) != '0)); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata)); // R12

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      endVec[i] |-> !activeVec[i]); // R5
  end
endmodule

bind wdc_bank wdc_checker u_chk (
  .clk(clk), .rstN(rstN), .busRd(busRd), .busRdata(busRdata), .rstReq(rstReq),
  .wdSel(wdSel), .activeVec(activeVec), .endVec(endVec)
);

// File: tb/tb_wdc_bank.sv
module tb_wdc_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rstReq;
  int          checks = 0, fails = 0, edgeCnt = 0;

  wdc_bank dut (.clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .rstReq(rstReq));

  always #4 clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busRd = 1'b1; busAddr = a;
    @(negedge clk); busRd = 1'b0; d = busRdata;
  endtask

  task automatic waitTo(input int target);
    if (edgeCnt > target - 1) chk("SCHED", 64'(edgeCnt), 64'(target - 1));
    while (edgeCnt < target - 1) @(negedge clk);
  endtask

  task automatic wrAt(input int target, input logic [7:0] a, input logic [31:0] d);
    waitTo(target);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rdAt(input int target, input logic [7:0] a, output logic [31:0] d);
    waitTo(target);
    busRd = 1'b1; busAddr = a;
    @(negedge clk); busRd = 1'b0; d = busRdata;
  endtask

  task automatic measure(input int e0, output int n);
    n = edgeCnt - e0;
    while (!rstReq && n < 600) begin
      @(negedge clk);
      n = edgeCnt - e0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, e0, ld, pe;
    doReset();
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(8'(i * 16), d);     chk("R1 ctrl", d, 0);
      rd(8'(i * 16 + 4), d); chk("R1 low", d, 0);
    end
    rd(8'h40, d); chk("R1 sel", d, 0);
    chk("R1 rstReq", rstReq, 0);

    // R2 field layout, active read-only; R8/R12 select readback
    wr(8'h20, 32'hFFFF_FFFE); rd(8'h20, d); chk("R2 ctrl2", d, 32'h0000_FFFC);
    wr(8'h30, 32'h0000_A551); rd(8'h30, d); chk("R2 ctrl3", d, 32'h0000_A551);
    wr(8'h40, 32'h0000_001A); rd(8'h40, d); chk("R8 R12 sel", d, 32'h0000_000A);

    // R3 R5 R8 sweep of prescaler and reload, one-shot on counter 0
    for (int p = 0; p < 5; p++) begin
      for (int r = 0; r < 4; r++) begin
        doReset();
        wr(8'h40, 1); wr(8'h04, r); wr(8'h08, 0);
        wr(8'h00, 32'(p << 8) | 32'h1);
        e0 = edgeCnt;
        measure(e0, n);
        pe = (p < 2) ? 2 : p;
        chk($sformatf("R3 R5 P=%0d R=%0d", p, r), n, (r == 0) ? 1 : pe * r + 1);
      end
    end

    // R8 unselected counter, R7 idle after end and restart rules
    doReset();
    wr(8'h04, 2); wr(8'h00, 32'h0201);
    repeat (10) @(negedge clk);
    chk("R8 unselected", rstReq, 0);
    rd(8'h00, d); chk("R7 idle after end", d, 32'h0201);
    wr(8'h00, 32'h0201); rd(8'h00, d); chk("R7 re-enable ignored", d, 32'h0201);
    wr(8'h00, 32'h0200); wr(8'h00, 32'h0201);
    rd(8'h00, d); chk("R7 toggle restarts", d, 32'h0203);

    // R6 chain: counter 1 retriggered by counter 0
    doReset();
    wr(8'h40, 2); wr(8'h14, 5); wr(8'h10, 32'h025D);
    rd(8'h10, d); chk("R6 hw waits for trigger", d, 32'h025D);
    wr(8'h00, 32'h0201); e0 = edgeCnt;
    measure(e0, n); chk("R6 chain expiry", n, 12);

    // R6 wrap: counter 0 retriggered by counter 3
    doReset();
    wr(8'h40, 1); wr(8'h04, 3); wr(8'h00, 32'h025D);
    wr(8'h30, 32'h0201); e0 = edgeCnt;
    measure(e0, n); chk("R6 wrap expiry", n, 8);

    // R6 wrong source and disabled counter are not reloaded
    doReset();
    wr(8'h14, 7); wr(8'h10, 32'h024D);
    wr(8'h34, 7); wr(8'h30, 32'h025C);
    wr(8'h00, 32'h0201); wr(8'h20, 32'h0201);
    rd(8'h14, d); chk("R6 wrong src low", d, 0);
    rd(8'h10, d); chk("R6 wrong src ctrl", d, 32'h024D);
    rd(8'h34, d); chk("R6 disabled low", d, 0);
    rd(8'h30, d); chk("R6 disabled ctrl", d, 32'h025C);

    // R6 keep-alive pings, R10 collision, R9 stickiness
    doReset();
    wr(8'h40, 2); wr(8'h14, 8); wr(8'h10, 32'h025D);
    wr(8'h00, 32'h0201); ld = edgeCnt + 1;
    for (int k = 0; k < 6; k++) begin
      wr(8'h00, 32'h0200); wr(8'h00, 32'h0201); ld = edgeCnt + 1;
      repeat (6) @(negedge clk);
    end
    chk("R6 pings keep alive", rstReq, 0);
    wrAt(ld + 16 - 3, 8'h00, 32'h0200);
    wrAt(ld + 16 - 1, 8'h00, 32'h0201);
    waitTo(ld + 16 + 2);
    chk("R10 reload wins", rstReq, 0);
    measure(ld + 16, n); chk("R10 full new period", n, 17);
    wr(8'h40, 0); wr(8'h10, 0);
    repeat (5) @(negedge clk);
    chk("R9 sticky", rstReq, 1);

    // R11 R4 coherent high read across a borrow
    doReset();
    wr(8'h24, 1); wr(8'h28, 1);
    wr(8'h20, 32'h0201); e0 = edgeCnt;
    rdAt(e0 + 2, 8'h24, d);  chk("R4 R11 low", d, 1);
    rdAt(e0 + 6, 8'h28, d);  chk("R11 latched high", d, 1);
    rdAt(e0 + 8, 8'h24, d);  chk("R11 low after borrow", d, 32'hFFFF_FFFE);
    rdAt(e0 + 10, 8'h28, d); chk("R11 high after borrow", d, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule